// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick count and compares it against a programmable limit. Each enable strobe advances the count by one. Nominally the strobe arrives at 100 MHz, but turning host time into strobes is left to the logic around the block. Software may overwrite both registers. The top bit of each register is a control flag, not part of the value. In the count register that bit is a non-privileged-trap flag, kept beside the 63-bit counter. In the limit register that bit is an interrupt-disable flag.

Writing a non-zero limit arms a one-shot compare. The compare fires on the first accepted tick that brings the count to the limit or beyond it. If the limit is already at or below the count, it therefore fires on the very next tick. A firing raises a one-cycle match pulse. It also raises a one-cycle soft-interrupt set pulse, unless interrupts are disabled. The compare then stays idle until the limit is written again. A limit value of zero never arms.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is 0 and both flags are 1. Reading either register returns 64'h8000_0000_0000_0000, and neither pulse output is high.
- R2: Each cycle with `tick_en` high and `wr_en` low adds one to the count. Without `tick_en` the count holds.
- R3: A count write (`wr_sel`=0) loads bits 62:0 into the counter and stores bit 63 as the trap flag. A count read (`rd_sel`=0) returns the count with bit 63 equal to that flag.
- R4: A limit write (`wr_sel`=1) stores bit 63 as the disable flag and bits 62:0 as the compare value. A limit read (`rd_sel`=1) returns both, in those same positions.
- R5: A tick that brings the count to the compare value raises `match_o` for exactly one cycle, right after that clock edge.
- R6: A compare value of zero never produces a match, whatever the disable flag holds.
- R7: If the compare value is at or below the current count when it is written, the next accepted tick fires the match.
- R8: A match with the disable flag set pulses `match_o` but leaves `irq_set_o` low. A match with the flag clear pulses both outputs.
- R9: After firing, the compare stays idle and does not fire again until the limit is rewritten, even while the count keeps running.
- R10: Any write in a cycle where `tick_en` is high takes precedence: the tick is dropped, and no match is evaluated in that cycle.
- R11: Reset cancels an armed compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 limit |
| wr_data | input | 64 | Write value, flag in bit 63 |
| rd_sel | input | 1 | Read source: 0 count, 1 limit |
| rd_data | output | 64 | Selected register, flag in bit 63 |
| match_o | output | 1 | One-cycle compare match pulse |
| irq_set_o | output | 1 | One-cycle soft-interrupt set pulse |

## Verification
Every register write and every tick shows up at the ports one clock edge later. Reads are combinational views of the registers, so a read reflects the edge that has just passed. The match and interrupt pulses are registered in the same edge as the tick that fires them, so they appear together with the count value that reached the limit. The bench drives inputs on the falling edge and samples one time unit after the rising edge. Each expected value is therefore taken in the first cycle where it is due, and any pulse is checked to have cleared one cycle later.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
    parameter int TCK_W = 64;
    localparam int VAL_W = TCK_W - 1;
    localparam int FLAG_BIT = TCK_W - 1;

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic             npt;
    } cnt_state_t;

    typedef struct packed {
        logic [VAL_W-1:0] cmp;
        logic             dis;
        logic             armed;
        logic             hit;
        logic             irq;
    } cmp_state_t;
endpackage

// File: rtl/tick_count_unit.sv
module tick_count_unit
    import tick_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [TCK_W-1:0] data_i,
    output logic [VAL_W-1:0] val_o,
    output logic             npt_o
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.val = data_i[VAL_W-1:0];
            st_d.npt = data_i[FLAG_BIT];
        end else if (adv_i) begin
            st_d.val = st_q.val + VAL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.val <= '0;
            st_q.npt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;
    assign npt_o = st_q.npt;
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit
    import tick_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             load_i,
    input  logic [TCK_W-1:0] data_i,
    input  logic [VAL_W-1:0] cnt_i,
    output logic [VAL_W-1:0] cmp_o,
    output logic             dis_o,
    output logic             hit_o,
    output logic             irq_o
);
    cmp_state_t st_d, st_q;
    logic [VAL_W-1:0] cnt_next;

    assign cnt_next = cnt_i + VAL_W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        st_d.irq = 1'b0;
        if (load_i) begin
            st_d.cmp   = data_i[VAL_W-1:0];
            st_d.dis   = data_i[FLAG_BIT];
            st_d.armed = |data_i[VAL_W-1:0];
        end else if (adv_i && st_q.armed && (cnt_next >= st_q.cmp)) begin
            st_d.hit   = 1'b1;
            st_d.irq   = ~st_q.dis;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmp   <= '0;
            st_q.dis   <= 1'b1;
            st_q.armed <= 1'b0;
            st_q.hit   <= 1'b0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;
    assign dis_o = st_q.dis;
    assign hit_o = st_q.hit;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [TCK_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [TCK_W-1:0] rd_data,
    output logic             match_o,
    output logic             irq_set_o
);
    logic             adv;
    logic             load_cnt;
    logic             load_lim;
    logic [VAL_W-1:0] cnt_val;
    logic             npt_flag;
    logic [VAL_W-1:0] cmp_val;
    logic             dis_flag;

    assign adv      = tick_en & ~wr_en;
    assign load_cnt = wr_en & ~wr_sel;
    assign load_lim = wr_en & wr_sel;

    tick_count_unit u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .load_i (load_cnt),
        .data_i (wr_data),
        .val_o  (cnt_val),
        .npt_o  (npt_flag)
    );

    tick_cmp_unit u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv),
        .load_i (load_lim),
        .data_i (wr_data),
        .cnt_i  (cnt_val),
        .cmp_o  (cmp_val),
        .dis_o  (dis_flag),
        .hit_o  (match_o),
        .irq_o  (irq_set_o)
    );

    assign rd_data = rd_sel ? {dis_flag, cmp_val} : {npt_flag, cnt_val};
endmodule

// File: rtl/tick_cmp_chk.sv
module tick_cmp_chk
    import tick_cmp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [TCK_W-1:0] wr_data,
    input logic [VAL_W-1:0] cnt,
    input logic [VAL_W-1:0] cmp,
    input logic             dis,
    input logic             match,
    input logic             irq
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> (cnt == $past(cnt)));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en) |=> (cnt == $past(cnt) + VAL_W'(1)));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (cnt == $past(wr_data[VAL_W-1:0])));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);

    p_zero_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (cmp != '0));

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match && !dis));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick_en) |=> !match);
endmodule

bind tick_cmp_timer tick_cmp_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cnt     (cnt_val),
    .cmp     (cmp_val),
    .dis     (dis_flag),
    .match   (match_o),
    .irq     (irq_set_o)
);

// File: tb/sim_tick_cmp_timer.sv
module sim_tick_cmp_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        logic        sel;
        logic [63:0] data;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005},
        '{1'b0, 64'h8000_0000_0000_0123, 64'h8000_0000_0000_0123},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{1'b1, 64'h8000_0000_DEAD_BEEF, 64'h8000_0000_DEAD_BEEF},
        '{1'b1, 64'h7FFF_0000_0000_0001, 64'h7FFF_0000_0000_0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data;
    logic        match_o;
    logic        irq_set_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .match_o(match_o), .irq_set_o(irq_set_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic we, input logic sel, input logic [63:0] d);
        @(negedge clk);
        tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 64'd0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 64'd0);
    endtask

    task automatic rd_cnt(input string req, input logic [63:0] exp);
        rd_sel = 1'b0; #1;
        chk(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        #1;
        // R1: reset state
        rd_cnt("R1 count", 64'h8000_0000_0000_0000);
        rd_sel = 1'b1; #1;
        chk("R1 limit", rd_data, 64'h8000_0000_0000_0000);
        chk("R1 pulses", {62'd0, match_o, irq_set_o}, 64'd0);

        // R3/R4: write then read back, table driven
        for (int k = 0; k < NVEC; k++) begin
            cyc(1'b0, 1'b1, VECS[k].sel, VECS[k].data);
            idle();
            rd_sel = VECS[k].sel; #1;
            chk(VECS[k].sel ? "R4 limit readback" : "R3 count readback", rd_data, VECS[k].exp);
        end

        // R2: increment and hold
        cyc(1'b0, 1'b1, 1'b1, 64'd0);
        cyc(1'b0, 1'b1, 1'b0, 64'd10);
        ticks(3);
        rd_cnt("R2 three ticks", 64'd13);
        idle(); idle();
        rd_cnt("R2 hold", 64'd13);

        // R5/R9: match at limit, one-shot
        cyc(1'b0, 1'b1, 1'b0, 64'd0);
        cyc(1'b0, 1'b1, 1'b1, 64'd5);
        ticks(4);
        chk("R5 no early match", {63'd0, match_o}, 64'd0);
        ticks(1);
        rd_cnt("R5 count at match", 64'd5);
        chk("R5 match", {63'd0, match_o}, 64'd1);
        chk("R8 irq when enabled", {63'd0, irq_set_o}, 64'd1);
        ticks(1);
        chk("R5 pulse clears", {63'd0, match_o}, 64'd0);
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                ticks(1);
                seen += match_o;
            end
            chk("R9 no refire", seen, 0);
        end

        // R8: disabled compare
        cyc(1'b0, 1'b1, 1'b0, 64'd0);
        cyc(1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0003);
        ticks(3);
        chk("R8 match while disabled", {63'd0, match_o}, 64'd1);
        chk("R8 no irq while disabled", {63'd0, irq_set_o}, 64'd0);

        // R6: zero compare value
        cyc(1'b0, 1'b1, 1'b0, 64'd0);
        cyc(1'b0, 1'b1, 1'b1, 64'd0);
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                ticks(1);
                seen += match_o + irq_set_o;
            end
            chk("R6 zero never fires", seen, 0);
        end

        // R7: limit already behind count
        cyc(1'b0, 1'b1, 1'b0, 64'd100);
        cyc(1'b0, 1'b1, 1'b1, 64'd50);
        chk("R7 no match on write", {63'd0, match_o}, 64'd0);
        ticks(1);
        chk("R7 match next tick", {63'd0, match_o}, 64'd1);

        // R10: write wins over tick
        cyc(1'b0, 1'b1, 1'b0, 64'd20);
        cyc(1'b1, 1'b1, 1'b0, 64'd40);
        rd_cnt("R10 count write wins", 64'd40);
        cyc(1'b0, 1'b1, 1'b0, 64'd7);
        cyc(1'b1, 1'b1, 1'b1, 64'd8);
        rd_cnt("R10 tick dropped on limit write", 64'd7);
        chk("R10 no match on write cycle", {63'd0, match_o}, 64'd0);
        ticks(1);
        chk("R10 match after", {63'd0, match_o}, 64'd1);

        // R11: reset cancels armed compare
        cyc(1'b0, 1'b1, 1'b0, 64'd0);
        cyc(1'b0, 1'b1, 1'b1, 64'd3);
        do_reset();
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                ticks(1);
                seen += match_o;
            end
            chk("R11 armed compare cancelled", seen, 0);
        end
        rd_sel = 1'b1; #1;
        chk("R11 limit after reset", rd_data, 64'h8000_0000_0000_0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule